// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

The block produces a periodic interrupt from a slow time base. A single-cycle tick enable at 32768 Hz advances a binary divider chain. A 4-bit rate code selects which chain stage closes a period. Each closed period raises a sticky flag, and software clears that flag by reading the flag register. The interrupt request follows the flag whenever the interrupt enable is set.

The rate code does not map to the rate in a straight line. Code 0 stops all periodic events. Codes 3 through 15 halve the rate at each step, from 8192 Hz down to 2 Hz. Codes 1 and 2 give the same rates as codes 8 and 9.

A prescaler-hold input clears the chain and keeps it cleared. While it is high, no events occur. A one-cycle pulse marks each period end, so it can be observed or counted.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset the flag, the interrupt request and the period pulse are all low, and the divider chain is cleared.
- R2: With rate code 0, no period pulse occurs and the flag is never set, however many ticks arrive.
- R3: For rate codes 3 to 15, a period lasts 2^(code-1) ticks. Code 3 is 4 ticks (8192 Hz) and code 15 is 16384 ticks (2 Hz). Counted from a cleared chain, the first pulse ends exactly one period.
- R4: Rate code 1 gives a period of 128 ticks, the same as code 8. Rate code 2 gives a period of 256 ticks, the same as code 9.
- R5: While prescaler hold is high, the chain is held at zero and no pulse occurs. After hold is released, the first pulse comes after one full period of ticks.
- R6: The period pulse is high for exactly one clock. That clock is the one right after the clock edge that sampled the tick completing the period.
- R7: A period end sets the flag. The flag stays set until a flag-read strobe clears it. If a period end and a read fall in the same cycle, the flag stays set.
- R8: The interrupt request is high exactly when the flag is set and the interrupt enable is 1.
- R9: A change of rate code does not reset the chain. The new code takes effect on the chain's current count, so a pulse comes when the low (code-1) chain bits are all ones at a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle tick at 32768 Hz |
| rate_sel | input | 4 | Rate code |
| irq_en | input | 1 | Periodic interrupt enable |
| presc_hold | input | 1 | Holds the chain cleared while high |
| flag_rd | input | 1 | Flag register read strobe, clears the flag |
| per_flag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Interrupt request |
| per_pulse | output | 1 | One-clock pulse at each period end |

## Verification
The chain count cannot be seen at the ports. A wrong count therefore shows up only as a wrong spacing between pulses. The bench measures tick counts between pulses, from a cleared chain and after a rate change in mid-count. A fault in the chain appears at the latest within one selected period, which is at most 16384 ticks. A flag or request fault appears on the clock right after the edge that should have set or cleared the flag.

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider #(
  parameter int CNT_W  = 14,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              irq_en,
  input  logic              presc_hold,
  input  logic              flag_rd,
  output logic              per_flag,
  output logic              irq,
  output logic              per_pulse
);
  localparam int K_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] chain_q;
  logic [K_W-1:0]   tap_k;
  logic             tap_on;
  logic [CNT_W-1:0] tap_mask;
  logic             period_end;

  always_comb begin
    tap_on = 1'b1;
    case (rate_sel)
      RATE_W'(0): begin tap_on = 1'b0; tap_k = '0; end
      RATE_W'(1): tap_k = K_W'(7);
      RATE_W'(2): tap_k = K_W'(8);
      default:    tap_k = K_W'(rate_sel) - K_W'(1);
    endcase
  end

  assign tap_mask   = ~({CNT_W{1'b1}} << tap_k);
  assign period_end = tick_en & ~presc_hold & tap_on & ((chain_q & tap_mask) == tap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      per_flag  <= 1'b0;
      per_pulse <= 1'b0;
    end else begin
      if (presc_hold)   chain_q <= '0;
      else if (tick_en) chain_q <= chain_q + 1'b1;
      if (period_end)   per_flag <= 1'b1;
      else if (flag_rd) per_flag <= 1'b0;
      per_pulse <= period_end;
    end
  end

  assign irq = per_flag & irq_en;

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    presc_hold |=> !per_pulse);
  assert_code0_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !per_pulse);
  assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |-> per_flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && !flag_rd) |=> per_flag);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> (!per_pulse || $past(tick_en)));
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (per_flag && irq_en));
endmodule

// File: tb/periodic_irq_divider_tb.sv
module periodic_irq_divider_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd3;
  logic irq_en = 1'b0;
  logic presc_hold = 1'b0;
  logic flag_rd = 1'b0;
  logic per_flag, irq, per_pulse;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  periodic_irq_divider u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .irq_en(irq_en), .presc_hold(presc_hold), .flag_rd(flag_rd),
    .per_flag(per_flag), .irq(irq), .per_pulse(per_pulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(output logic p);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    p = per_pulse;
  endtask

  task automatic clear_chain;
    @(negedge clk) presc_hold = 1'b1;
    @(negedge clk) presc_hold = 1'b0;
  endtask

  task automatic read_flag;
    @(negedge clk) flag_rd = 1'b1;
    @(negedge clk) flag_rd = 1'b0;
  endtask

  task automatic ticks_to_pulse(input int limit, output int n);
    logic p;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      tick(p);
      if (p) begin n = i; break; end
    end
  endtask

  task automatic t_reset_R1;
    chk("R1 flag", per_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pulse", per_pulse, 0);
  endtask

  task automatic t_periods_R3;
    int n;
    for (int c = 3; c <= 15; c++) begin
      rate_sel = 4'(c);
      clear_chain();
      ticks_to_pulse(20000, n);
      chk($sformatf("R3 code %0d", c), n, 1 << (c - 1));
    end
    rate_sel = 4'd5;
    clear_chain();
    ticks_to_pulse(100, n);
    ticks_to_pulse(100, n);
    chk("R3 second period code 5", n, 16);
  endtask

  task automatic t_alias_R4;
    int n;
    rate_sel = 4'd1; clear_chain(); ticks_to_pulse(1000, n);
    chk("R4 code 1", n, 128);
    rate_sel = 4'd2; clear_chain(); ticks_to_pulse(1000, n);
    chk("R4 code 2", n, 256);
  endtask

  task automatic t_code0_R2;
    int n;
    read_flag();
    rate_sel = 4'd0; clear_chain();
    ticks_to_pulse(300, n);
    chk("R2 no pulse", n, 0);
    chk("R2 flag", per_flag, 0);
  endtask

  task automatic t_hold_R5;
    int n;
    logic p;
    int seen = 0;
    read_flag();
    rate_sel = 4'd3;
    @(negedge clk) presc_hold = 1'b1;
    for (int i = 0; i < 20; i++) begin tick(p); if (p) seen++; end
    chk("R5 pulses under hold", seen, 0);
    chk("R5 flag under hold", per_flag, 0);
    @(negedge clk) presc_hold = 1'b0;
    rate_sel = 4'd6;
    ticks_to_pulse(100, n);
    chk("R5 first period after release", n, 32);
  endtask

  task automatic t_pulse_width_R6;
    int n;
    rate_sel = 4'd3; clear_chain();
    ticks_to_pulse(10, n);
    chk("R6 pulse seen", n, 4);
    @(negedge clk);
    chk("R6 pulse one clock", per_pulse, 0);
  endtask

  task automatic t_flag_R7_R8;
    logic p;
    read_flag();
    chk("R7 read clears", per_flag, 0);
    irq_en = 1'b0;
    rate_sel = 4'd3; clear_chain();
    for (int i = 0; i < 4; i++) tick(p);
    chk("R7 flag set", per_flag, 1);
    chk("R8 irq masked", irq, 0);
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    chk("R8 irq on", irq, 1);
    for (int i = 0; i < 3; i++) tick(p);
    chk("R7 sticky", per_flag, 1);
    read_flag();
    chk("R7 cleared", per_flag, 0);
    chk("R8 irq off", irq, 0);
    @(negedge clk) begin tick_en = 1'b1; flag_rd = 1'b1; end
    @(negedge clk) begin tick_en = 1'b0; flag_rd = 1'b0; end
    chk("R7 set beats read", per_flag, 1);
    irq_en = 1'b0;
  endtask

  task automatic t_rate_change_R9;
    int n;
    logic p;
    rate_sel = 4'd3; clear_chain();
    tick(p); tick(p);
    rate_sel = 4'd4;
    ticks_to_pulse(20, n);
    chk("R9 no chain reset", n, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_periods_R3();
    t_alias_R4();
    t_code0_R2();
    t_hold_R5();
    t_pulse_width_R6();
    t_flag_R7_R8();
    t_rate_change_R9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule